// File: doc/BRIEF.md
# Scan Chain Length Checker

This block is a small JTAG master that checks the length of one device's boundary register before any interconnect test is run. A single instruction scan loads the whole chain: the device under test gets its sampling instruction and every other device gets BYPASS. The block then runs one data scan. That scan first flushes the path with zeros, then injects a single one, then counts TCK cycles until the one comes back on TDO.

The count covers the whole selected path. Each bypassed device adds one bit of delay, so the bypass count supplied by the caller is subtracted from it. The result is compared with the expected boundary length. The block reports pass, a measured length, and two fault flags. One flag marks a path on which the marker never returns. The other marks a path that shows ones while it should hold only flushed zeros.

The TAP pins come from a divided system clock: one TCK period lasts two system clocks. A run starts on a one-clock `start` pulse and ends with a one-clock `done` pulse. The results stay on the outputs until the next run begins.

Top module: `scan_len_checker`

## Requirements
- R1: At start the block drives five TCK cycles with TMS high, which resets every TAP in the chain from any state. It then walks through Run-Test/Idle, Select-DR and Select-IR into Shift-IR.
- R2: A single IR scan shifts all NDEV*IR_W bits of `ir_word`, bit 0 first. TMS is high only on the final bit. After Update-IR the chain holds exactly `ir_word`, with bit 0 nearest TDO.
- R3: Each TCK period is two system clocks and the high phase lasts exactly one clock. TMS and TDI change only at the falling edge of TCK, and stay stable while TCK is high.
- R4: The data scan begins with 2*`max_len` zero bits on TDI. If TDO shows a one in any flush slot numbered above `max_len`, `flt_stuck1` is set.
- R5: After the flush, one bit of value one is shifted in, followed by zeros. N is the number of TCK rising edges from the injection until the first one is seen on TDO. `meas_len` = N − `n_byp`.
- R6: `pass` is 1 only when the marker returned, no stuck-at-one fault was seen, and N equals `exp_len` + `n_byp`. Otherwise it is 0.
- R7: If the marker has not returned after `max_len` hunt cycles, the block sets `flt_open`, clears `pass` and reports a `meas_len` of 0. A path of exactly `max_len` bits is still measured.
- R8: After the measurement the block leaves Shift-DR through Exit1-DR and Update-DR, and ends in Run-Test/Idle with TCK parked low. `done` is high for exactly one system clock, and the results hold until the next start.
- R9: A `start` pulse during a run is ignored. Changes to `ir_word`, `n_byp`, `exp_len` or `max_len` during a run do not change that run's scans or its results.
- R10: After reset the outputs are TCK 0, TMS 1, TDI 0, and `done`, `pass`, `flt_open`, `flt_stuck1` and `meas_len` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock pulse that begins a run |
| ir_word | input | NDEV*IR_W | Concatenated instructions for the whole chain, bit 0 shifted first |
| n_byp | input | LEN_W | Number of bypassed devices in the selected path |
| exp_len | input | LEN_W | Expected boundary register length |
| max_len | input | LEN_W | Longest total path searched (at least 1) |
| tck | output | 1 | Test clock to the chain |
| tms | output | 1 | Test mode select to the chain |
| tdi | output | 1 | Serial data into the chain |
| tdo | input | 1 | Serial data out of the chain |
| done | output | 1 | One-clock pulse when a run finishes |
| pass | output | 1 | Measured length equals the expected length |
| meas_len | output | LEN_W | Measured boundary length (0 on timeout) |
| flt_open | output | 1 | Marker not returned within `max_len` |
| flt_stuck1 | output | 1 | A one was seen during the late flush |

## Verification
The bench sweeps boundary lengths against bypass counts, with both matching and off-by-one expectations. An off-by-one in the injection slot or in the TDO sampling point would show up as every measured length being one too large or too small. The bench also tests a path exactly `max_len` bits long and one a single bit longer: a search bound that is one slot short would wrongly time out the first, and one that is one slot long would wrongly measure the second. A chain model loads capture data of alternating ones. A stuck-at-one window that opened too early would flag a good chain. A forced-high TDO and a forced-low TDO must raise the matching fault flag and clear `pass`. A `start` pulse with altered inputs in the middle of a run must leave both the loaded instructions and the verdict unchanged.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_IRH, S_IRS, S_MID, S_FLUSH, S_INJ, S_HUNT, S_EXIT, S_DONE
  } seq_t;

  typedef enum logic [1:0] {OB_NONE, OB_ZERO, OB_HUNT} obs_t;
endpackage

// File: rtl/slc_tck_gen.sv
module slc_tck_gen (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tdo,
  output logic tck,
  output logic tick,
  output logic tdo_s
);
  logic ph;

  always_ff @(posedge clk) begin
    if (rst || !run) ph <= 1'b0;
    else             ph <= ~ph;
    if (rst) tdo_s <= 1'b0;
    else     tdo_s <= tdo;
  end

  assign tck  = ph;
  assign tick = run & ph;
endmodule

// File: rtl/slc_meter.sv
module slc_meter import slc_pkg::*; #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  obs_t             obs,
  input  logic [LEN_W-1:0] hidx,
  input  logic [LEN_W-1:0] max_q,
  input  logic             tdo_s,
  output logic             stop,
  output logic             found,
  output logic [LEN_W-1:0] n_q,
  output logic             open_q,
  output logic             stuck_q
);
  assign stop = tick && (obs == OB_HUNT) && (tdo_s || (hidx == max_q));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      found   <= 1'b0;
      n_q     <= '0;
      open_q  <= 1'b0;
      stuck_q <= 1'b0;
    end else if (tick) begin
      case (obs)
        OB_ZERO: if (tdo_s) stuck_q <= 1'b1;
        OB_HUNT: begin
          if (tdo_s) begin
            found <= 1'b1;
            n_q   <= hidx;
          end else if (hidx == max_q) begin
            open_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/slc_seq.sv
module slc_seq import slc_pkg::*; #(
  parameter int IR_TOT = 16,
  parameter int LEN_W  = 10,
  parameter int CW     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic              stop,
  input  logic [IR_TOT-1:0] ir_word,
  input  logic [LEN_W-1:0]  max_len,
  output logic              run,
  output logic              tms,
  output logic              tdi,
  output logic              clr,
  output logic              fin,
  output obs_t              obs,
  output logic [LEN_W-1:0]  hidx,
  output logic [LEN_W-1:0]  max_q
);
  localparam int         RST_N   = 5;
  localparam logic [4:0] IRH_PAT = 5'b00110;
  localparam logic [4:0] MID_PAT = 5'b00101;

  seq_t              st;
  logic [CW-1:0]     cnt;
  logic [IR_TOT-1:0] ir_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      ir_sh <= '0;
      max_q <= '0;
      hidx  <= '0;
      obs   <= OB_NONE;
      run   <= 1'b0;
      tms   <= 1'b1;
      tdi   <= 1'b0;
      clr   <= 1'b0;
      fin   <= 1'b0;
    end else begin
      clr <= 1'b0;
      fin <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          ir_sh <= ir_word;
          max_q <= max_len;
          tms   <= 1'b1;
          tdi   <= 1'b0;
          obs   <= OB_NONE;
          cnt   <= CW'(1);
          run   <= 1'b1;
          clr   <= 1'b1;
          st    <= S_RST;
        end
      end else if (tick) begin
        obs <= OB_NONE;
        tdi <= 1'b0;
        case (st)
          S_RST: begin
            tms <= 1'b1;
            if (cnt == CW'(RST_N - 1)) begin st <= S_IRH; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          S_IRH: begin
            tms <= IRH_PAT[cnt[2:0]];
            if (cnt == CW'(4)) begin st <= S_IRS; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          S_IRS: begin
            tdi   <= ir_sh[0];
            ir_sh <= ir_sh >> 1;
            tms   <= (cnt == CW'(IR_TOT - 1));
            if (cnt == CW'(IR_TOT - 1)) begin st <= S_MID; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          S_MID: begin
            tms <= MID_PAT[cnt[2:0]];
            if (cnt == CW'(4)) begin st <= S_FLUSH; cnt <= CW'(1); end
            else cnt <= cnt + 1'b1;
          end
          S_FLUSH: begin
            tms <= 1'b0;
            obs <= (cnt > CW'(max_q)) ? OB_ZERO : OB_NONE;
            if (cnt == CW'({max_q, 1'b0})) st <= S_INJ;
            else cnt <= cnt + 1'b1;
          end
          S_INJ: begin
            tms <= 1'b0;
            tdi <= 1'b1;
            cnt <= CW'(1);
            st  <= S_HUNT;
          end
          S_HUNT: begin
            if (stop) begin
              tms <= 1'b1;
              cnt <= '0;
              st  <= S_EXIT;
            end else begin
              tms  <= 1'b0;
              obs  <= OB_HUNT;
              hidx <= cnt[LEN_W-1:0];
              cnt  <= cnt + 1'b1;
            end
          end
          S_EXIT: begin
            tms <= (cnt == '0);
            if (cnt == CW'(1)) st <= S_DONE;
            else cnt <= cnt + 1'b1;
          end
          S_DONE: begin
            tms <= 1'b0;
            run <= 1'b0;
            fin <= 1'b1;
            st  <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/scan_len_checker.sv
module scan_len_checker import slc_pkg::*; #(
  parameter int NDEV  = 4,
  parameter int IR_W  = 4,
  parameter int LEN_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [NDEV*IR_W-1:0]   ir_word,
  input  logic [LEN_W-1:0]       n_byp,
  input  logic [LEN_W-1:0]       exp_len,
  input  logic [LEN_W-1:0]       max_len,
  output logic                   tck,
  output logic                   tms,
  output logic                   tdi,
  input  logic                   tdo,
  output logic                   done,
  output logic                   pass,
  output logic [LEN_W-1:0]       meas_len,
  output logic                   flt_open,
  output logic                   flt_stuck1
);
  localparam int IR_TOT = NDEV * IR_W;
  localparam int CW     = (LEN_W + 1 > $clog2(IR_TOT + 1)) ? LEN_W + 1 : $clog2(IR_TOT + 1);

  logic             run, tick, tdo_s, stop, clr, fin;
  logic             found, open_q, stuck_q;
  obs_t             obs;
  logic [LEN_W-1:0] hidx, max_q, n_q, exp_q, nbyp_q;
  logic [LEN_W:0]   tgt;

  slc_tck_gen u_tck (
    .clk(clk), .rst(rst), .run(run), .tdo(tdo),
    .tck(tck), .tick(tick), .tdo_s(tdo_s)
  );

  slc_seq #(.IR_TOT(IR_TOT), .LEN_W(LEN_W), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .stop(stop),
    .ir_word(ir_word), .max_len(max_len),
    .run(run), .tms(tms), .tdi(tdi), .clr(clr), .fin(fin),
    .obs(obs), .hidx(hidx), .max_q(max_q)
  );

  slc_meter #(.LEN_W(LEN_W)) u_meter (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick), .obs(obs),
    .hidx(hidx), .max_q(max_q), .tdo_s(tdo_s),
    .stop(stop), .found(found), .n_q(n_q), .open_q(open_q), .stuck_q(stuck_q)
  );

  assign tgt = {1'b0, exp_q} + {1'b0, nbyp_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q      <= '0;
      nbyp_q     <= '0;
      done       <= 1'b0;
      pass       <= 1'b0;
      meas_len   <= '0;
      flt_open   <= 1'b0;
      flt_stuck1 <= 1'b0;
    end else begin
      done <= fin;
      if (start && !run) begin
        exp_q  <= exp_len;
        nbyp_q <= n_byp;
      end
      if (clr) begin
        pass       <= 1'b0;
        meas_len   <= '0;
        flt_open   <= 1'b0;
        flt_stuck1 <= 1'b0;
      end else if (fin) begin
        pass       <= found && !stuck_q && ({1'b0, n_q} == tgt);
        meas_len   <= found ? (n_q - nbyp_q) : '0;
        flt_open   <= open_q;
        flt_stuck1 <= stuck_q;
      end
    end
  end
endmodule

// File: rtl/slc_chk.sv
module slc_chk #(
  parameter int LEN_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             tck,
  input logic             tms,
  input logic             tdi,
  input logic             done,
  input logic             pass,
  input logic             flt_open,
  input logic             flt_stuck1,
  input logic [LEN_W-1:0] meas_len
);
  p_tck_high_one_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tck) |=> !tck);

  p_pins_hold_r3: assert property (@(posedge clk) disable iff (rst)
    tck |-> ($stable(tms) && $stable(tdi)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_parked_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !tck);

  p_pass_clean_r6: assert property (@(posedge clk) disable iff (rst)
    pass |-> (!flt_open && !flt_stuck1));

  p_open_zero_r7: assert property (@(posedge clk) disable iff (rst)
    flt_open |-> (meas_len == '0));
endmodule

bind scan_len_checker slc_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .done(done),
  .pass(pass), .flt_open(flt_open), .flt_stuck1(flt_stuck1), .meas_len(meas_len)
);

// File: tb/sim_scan_len_checker.sv
`timescale 1ns/1ps
module sim_scan_len_checker;
  localparam int NDEV = 4, IRW = 3, LW = 8, IRT = NDEV * IRW;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, tdo;
  logic [IRT-1:0] ir_word = '0;
  logic [LW-1:0]  n_byp = '0, exp_len = '0, max_len = '0;
  logic tck, tms, tdi, done, pass, flt_open, flt_stuck1;
  logic [LW-1:0]  meas_len;

  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  scan_len_checker #(.NDEV(NDEV), .IR_W(IRW), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .start(start), .ir_word(ir_word), .n_byp(n_byp),
    .exp_len(exp_len), .max_len(max_len), .tck(tck), .tms(tms), .tdi(tdi),
    .tdo(tdo), .done(done), .pass(pass), .meas_len(meas_len),
    .flt_open(flt_open), .flt_stuck1(flt_stuck1)
  );

  // chain model: one TAP, an N-bit delay path for DR, IRT-bit IR
  int tap = 6;
  int path_n = 4;
  int fmode = 0;
  logic [63:0] dr = '0;
  logic [IRT-1:0] ir_sh = '0, ir_upd = '0;
  logic tdo_m = 1'b0;
  bit seen_tlr = 0;

  function automatic int nxt(input int s, input logic m);
    case (s)
      0: return m ? 0 : 1;   1: return m ? 2 : 1;
      2: return m ? 9 : 3;   3: return m ? 5 : 4;
      4: return m ? 5 : 4;   5: return m ? 8 : 6;
      6: return m ? 7 : 6;   7: return m ? 8 : 4;
      8: return m ? 2 : 1;   9: return m ? 0 : 10;
      10: return m ? 12 : 11; 11: return m ? 12 : 11;
      12: return m ? 15 : 13; 13: return m ? 14 : 13;
      14: return m ? 15 : 11; default: return m ? 2 : 1;
    endcase
  endfunction

  always @(posedge tck) begin
    case (tap)
      3:  dr = {32{2'b10}};
      4:  begin
            for (int i = 0; i < 63; i++) if (i < path_n - 1) dr[i] = dr[i+1];
            dr[path_n-1] = tdi;
          end
      10: ir_sh = {{(IRT-2){1'b0}}, 2'b01};
      11: ir_sh = {tdi, ir_sh[IRT-1:1]};
      15: ir_upd = ir_sh;
      default: ;
    endcase
    tap = nxt(tap, tms);
    if (tap == 0) seen_tlr = 1;
  end

  always @(negedge tck) tdo_m = (tap == 4) ? dr[0] : (tap == 11) ? ir_sh[0] : 1'b0;
  assign tdo = (fmode == 1) ? 1'b1 : (fmode == 2) ? 1'b0 : tdo_m;

  // R3 pin monitor
  logic tms_r = 1'b1, tdi_r = 1'b0;
  int hi_run = 0, r3_bad = 0, ndone = 0;
  always @(posedge tck) begin tms_r = tms; tdi_r = tdi; end
  always @(negedge clk) begin
    if (done) ndone++;
    if (tck) begin
      hi_run++;
      if (tms !== tms_r || tdi !== tdi_r) r3_bad++;
      if (hi_run > 1) r3_bad++;
    end else hi_run = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_case(input int L, input int nb, input int ex, input int mx,
                          input int fm, input bit poke);
    int n, w, e_meas;
    bit e_pass, e_open, e_st;
    logic [IRT-1:0] iw;
    n = L + nb;
    iw = IRT'(L * 181 + nb * 29 + ex * 7 + 5);
    path_n = n; fmode = fm; seen_tlr = 0; ndone = 0;
    @(negedge clk);
    ir_word = iw; n_byp = LW'(nb); exp_len = LW'(ex); max_len = LW'(mx); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      ir_word = ~iw; exp_len = LW'(ex + 3); n_byp = '0; max_len = LW'(2); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    chk(done, "R8 done seen", int'(done), 1);
    e_st = (fm == 1);
    e_open = (fm == 2) || (fm == 0 && n > mx);
    e_pass = (fm == 0) && (n <= mx) && (L == ex);
    e_meas = e_open ? 0 : L;
    chk(pass == e_pass, poke ? "R9 pass" : "R6 pass", int'(pass), int'(e_pass));
    chk(flt_open == e_open, "R7 open flag", int'(flt_open), int'(e_open));
    if (fm != 0 || n <= mx)
      chk(flt_stuck1 == e_st, "R4 stuck flag", int'(flt_stuck1), int'(e_st));
    if (fm != 1)
      chk(int'(meas_len) == e_meas, poke ? "R9 length" : "R5 length", int'(meas_len), e_meas);
    chk(ir_upd == iw, "R2 ir loaded", int'(ir_upd), int'(iw));
    chk(seen_tlr, "R1 tap reset", int'(seen_tlr), 1);
    repeat (3) @(negedge clk);
    chk(tap == 1, "R8 ends idle", tap, 1);
    chk(ndone == 1, "R8 done width", ndone, 1);
    chk(int'(meas_len) == e_meas || fm == 1, "R8 result held", int'(meas_len), e_meas);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tck == 1'b0 && tms == 1'b1 && tdi == 1'b0, "R10 pins", {tck, tms, tdi}, 3'b010);
    chk(!done && !pass && !flt_open && !flt_stuck1 && meas_len == '0, "R10 results",
        {done, pass, flt_open, flt_stuck1}, 0);
    for (int L = 1; L <= 10; L++)
      for (int nb = 0; nb <= 3; nb++) begin
        run_case(L, nb, L, 16, 0, 0);
        run_case(L, nb, L + 1, 16, 0, 0);
      end
    run_case(14, 2, 14, 16, 0, 0);   // R7 path exactly at search limit
    run_case(12, 0, 12, 12, 0, 0);   // R7 limit with no bypass
    run_case(15, 2, 15, 16, 0, 0);   // R7 one past limit -> open
    run_case(5, 1, 5, 16, 1, 0);     // R4 stuck-at-one
    run_case(5, 1, 5, 16, 2, 0);     // R7 stuck-at-zero
    run_case(7, 3, 7, 16, 0, 1);     // R9 start during run
    chk(r3_bad == 0, "R3 pin timing", r3_bad, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule